// File: doc/BRIEF.md
# Host Packet Insert Mailbox

This block lets a host processor push one packet fragment burst into a byte-wide egress stream. The host sees a small address space. Three header bytes (flags, length and channel) come first, then up to 256 payload bytes, then one control byte. The host first polls the control byte until its owner bit reads zero. It then fills the header and payload and writes the owner bit to one. From that point the hardware owns the buffer.

While it owns the buffer, the block plays the burst out on a valid/ready stream. Each byte carries start-of-packet, end-of-packet, end-of-burst, error and channel sideband. One cycle after the final byte is accepted, the block returns the buffer to the host: it drops the owner bit and raises a single-cycle empty event for the interrupt logic. Any write the host makes while the hardware owns the buffer is discarded.

Top module: `pkt_insert_mbox`

## Requirements
- R1: After synchronous reset, the owner bit reads 0, `out_valid` is low and `insert_empty_irq` is low.
- R2: The host address map is as follows. Address 0 is the flags byte, 1 the length byte, 2 the channel byte, and 3+n payload byte n (n = 0..255). Address 259 is the control byte, and addresses above 259 read as zero. A read pulse returns the addressed byte on `host_rd_data` after the next clock edge. Flags bits 7:5 always read as 0.
- R3: Host writes to any address are ignored while the owner bit is 1, so the buffer contents and the control byte are left unchanged.
- R4: A host write to address 259 with data bit 0 set, made while the owner bit is 0, sets the owner bit. The control byte reads as {7'b0, owner}. `out_valid` is only ever high while the owner bit is 1.
- R5: Once owned, the burst is played out as length+1 bytes. `out_valid` rises one cycle after the owner bit is set, and the payload bytes 0, 1, 2, ... are presented in address order on `out_data`.
- R6: `out_sop` equals flags bit 0 on the first byte and is 0 on every other byte. `out_chan` carries the channel byte on every byte of the burst.
- R7: `out_last` is high on the final byte only. On that byte `out_eop` equals flags bit 1 and `out_err[2:0]` equals flags bits {4,3,2} (data parity, address parity, packet error). On all other bytes both are zero.
- R8: A byte advances only on a cycle where `out_valid` and `out_ready` are both high. Under back-pressure `out_valid` and the byte sideband hold steady.
- R9: If the final byte is accepted at clock edge k, the owner bit reads 0 and `insert_empty_irq` is high after edge k+1, and `insert_empty_irq` is low again after edge k+2.
- R10: Both length extremes work: a length of 0 sends exactly one byte and a length of 255 sends exactly 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 9 | Host byte address for read and write |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 8 | Host write data |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 8 | Registered host read data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accept |
| out_data | output | 8 | Stream payload byte |
| out_sop | output | 1 | Start of packet, first byte only |
| out_eop | output | 1 | End of packet, last byte only |
| out_last | output | 1 | End of burst marker |
| out_err | output | 3 | Error flags on last byte: {data parity, address parity, packet} |
| out_chan | output | 8 | Channel ID of the burst |
| insert_empty_irq | output | 1 | One-cycle event when ownership returns to host |

## Verification
The bench attacks the length extremes. A single-byte burst must carry start, end-of-burst, end-of-packet and errors all on the same byte, and a 256-byte burst must not wrap its index early. An off-by-one design would emit one byte too many or too few, or put the end marker on the wrong byte. Back-pressure is applied in random patterns and as a long stall. This catches a design that advances without a handshake or lets the data change under a stall. Writes and a second ownership request are issued mid-burst and then read back afterwards. A design that does not lock the buffer would corrupt the stream or the stored bytes, or would keep the owner bit set. The event timing is compared cycle by cycle, so a release one cycle early or late, or an event pulse two cycles wide, shows up as a mismatch.

// File: rtl/insb_pkg.sv
package insb_pkg;

    localparam int HDR_BYTES = 3;
    localparam int FLAGS_LOC = 0;
    localparam int LEN_LOC   = 1;
    localparam int CHAN_LOC  = 2;

    // Only the five meaningful flag bits are kept; upper bits read as zero.
    typedef struct packed {
        logic dpar_err;
        logic apar_err;
        logic pkt_err;
        logic eop;
        logic sop;
    } burst_flags_t;

    typedef struct packed {
        burst_flags_t flags;
        logic [7:0]   len_m1;
        logic [7:0]   chan;
    } burst_hdr_t;

    typedef enum logic [1:0] {
        PL_IDLE = 2'd0,
        PL_PLAY = 2'd1,
        PL_DONE = 2'd2
    } play_state_t;

    function automatic logic [7:0] flags_to_byte(input burst_flags_t f);
        return {3'b000, f};
    endfunction

endpackage

// File: rtl/insb_store.sv
module insb_store
    import insb_pkg::*;
#(
    parameter int PAY_MAX = 256,
    parameter int ADDR_W  = 9,
    localparam int IDX_W  = $clog2(PAY_MAX),
    localparam int IMG    = HDR_BYTES + PAY_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              locked,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [7:0]        ctrl_byte,
    output logic [7:0]        rd_data,
    output burst_hdr_t        hdr,
    input  logic [IDX_W-1:0]  play_idx,
    output logic [7:0]        play_byte
);

    logic [7:0]       payload [PAY_MAX];
    logic             wr_ok;
    logic             in_pay;
    logic [IDX_W-1:0] pay_idx;

    assign wr_ok   = wr_en && !locked;
    assign in_pay  = (addr >= ADDR_W'(HDR_BYTES)) && (addr < ADDR_W'(IMG));
    assign pay_idx = IDX_W'(addr - ADDR_W'(HDR_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
        end else if (wr_ok) begin
            if (addr == ADDR_W'(FLAGS_LOC)) hdr.flags  <= burst_flags_t'(wr_data[4:0]);
            if (addr == ADDR_W'(LEN_LOC))   hdr.len_m1 <= wr_data;
            if (addr == ADDR_W'(CHAN_LOC))  hdr.chan   <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && in_pay) payload[pay_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (addr == ADDR_W'(FLAGS_LOC))     rd_data <= flags_to_byte(hdr.flags);
            else if (addr == ADDR_W'(LEN_LOC))  rd_data <= hdr.len_m1;
            else if (addr == ADDR_W'(CHAN_LOC)) rd_data <= hdr.chan;
            else if (in_pay)                    rd_data <= payload[pay_idx];
            else if (addr == ADDR_W'(IMG))      rd_data <= ctrl_byte;
            else                                rd_data <= '0;
        end
    end

    assign play_byte = payload[play_idx];

    // R3
    hdr_locked_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(hdr));

endmodule

// File: rtl/insb_player.sv
module insb_player
    import insb_pkg::*;
#(
    parameter int PAY_MAX = 256,
    localparam int IDX_W  = $clog2(PAY_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             owned,
    input  burst_hdr_t       hdr,
    input  logic [7:0]       byte_in,
    output logic [IDX_W-1:0] idx,
    output logic             release_o,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_last,
    output logic [2:0]       out_err,
    output logic [7:0]       out_chan
);

    play_state_t st;
    logic        at_last;
    logic        accept;

    assign at_last = (idx == IDX_W'(hdr.len_m1));
    assign accept  = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PL_IDLE;
            idx <= '0;
        end else begin
            unique case (st)
                PL_IDLE: if (owned) begin
                    st  <= PL_PLAY;
                    idx <= '0;
                end
                PL_PLAY: if (accept) begin
                    if (at_last) st <= PL_DONE;
                    else         idx <= idx + 1'b1;
                end
                PL_DONE: st <= PL_IDLE;
                default: st <= PL_IDLE;
            endcase
        end
    end

    assign out_valid = (st == PL_PLAY);
    assign release_o = (st == PL_DONE);
    assign out_data  = byte_in;
    assign out_chan  = out_valid ? hdr.chan : 8'h00;
    assign out_sop   = out_valid && (idx == '0) && hdr.flags.sop;
    assign out_last  = out_valid && at_last;
    assign out_eop   = out_last && hdr.flags.eop;
    assign out_err   = out_last ? {hdr.flags.dpar_err, hdr.flags.apar_err, hdr.flags.pkt_err} : 3'b000;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_sop)));

    // R5
    end_of_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: rtl/pkt_insert_mbox.sv
module pkt_insert_mbox
    import insb_pkg::*;
#(
    parameter int PAY_MAX   = 256,
    localparam int IMG_BYTES = HDR_BYTES + PAY_MAX,
    localparam int ADDR_W    = $clog2(IMG_BYTES + 1),
    localparam int IDX_W     = $clog2(PAY_MAX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr_en,
    input  logic [7:0]        host_wr_data,
    input  logic              host_rd_en,
    output logic [7:0]        host_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_last,
    output logic [2:0]        out_err,
    output logic [7:0]        out_chan,
    output logic              insert_empty_irq
);

    logic             owned;
    logic             release_w;
    burst_hdr_t       hdr;
    logic [IDX_W-1:0] play_idx;
    logic [7:0]       play_byte;
    logic             claim;

    assign claim = host_wr_en && !owned && (host_addr == ADDR_W'(IMG_BYTES)) && host_wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            owned            <= 1'b0;
            insert_empty_irq <= 1'b0;
        end else begin
            insert_empty_irq <= release_w;
            if (release_w)  owned <= 1'b0;
            else if (claim) owned <= 1'b1;
        end
    end

    insb_store #(.PAY_MAX(PAY_MAX), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .locked    (owned),
        .addr      (host_addr),
        .wr_en     (host_wr_en),
        .wr_data   (host_wr_data),
        .rd_en     (host_rd_en),
        .ctrl_byte ({7'b0, owned}),
        .rd_data   (host_rd_data),
        .hdr       (hdr),
        .play_idx  (play_idx),
        .play_byte (play_byte)
    );

    insb_player #(.PAY_MAX(PAY_MAX)) u_player (
        .clk       (clk),
        .rst       (rst),
        .owned     (owned),
        .hdr       (hdr),
        .byte_in   (play_byte),
        .idx       (play_idx),
        .release_o (release_w),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_last  (out_last),
        .out_err   (out_err),
        .out_chan  (out_chan)
    );

    // R4
    valid_owned_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> owned);

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        insert_empty_irq |=> !insert_empty_irq);

    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(owned) |-> insert_empty_irq);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!owned && !out_valid && !insert_empty_irq));

endmodule

// File: tb/test_pkt_insert_mbox.sv
`timescale 1ns/1ps
module test_pkt_insert_mbox;

    localparam int IMG  = 259;
    localparam int CTRL = 259;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] host_addr = '0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_rd_data;
    logic       out_valid, out_sop, out_eop, out_last, insert_empty_irq;
    logic       out_ready = 1'b1;
    logic [7:0] out_data, out_chan;
    logic [2:0] out_err;

    always #2.5 clk = ~clk;

    pkt_insert_mbox i_pkt_insert_mbox (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_last(out_last), .out_err(out_err),
        .out_chan(out_chan), .insert_empty_irq(insert_empty_irq)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int acc_cnt = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    string rd_tag = "R2";

    // behavioural reference state
    logic [7:0] img [IMG];
    logic m_avail = 0, m_play = 0, m_done = 0, m_evt = 0, m_rd_pend = 0;
    int   m_pos = 0;
    logic [7:0] m_rd_exp = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_read(input int a);
        if (a == 0)        return img[0] & 8'h1F;
        else if (a < IMG)  return img[a];
        else if (a == CTRL) return {7'b0, m_avail};
        else               return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic o_avail;
        o_avail = m_avail;
        if (rst) begin
            m_avail = 0; m_play = 0; m_done = 0; m_evt = 0; m_rd_pend = 0; m_pos = 0;
        end else begin
            m_evt = 0;
            m_rd_pend = host_rd_en;
            if (host_rd_en) m_rd_exp = ref_read(int'(host_addr));
            if (m_done) begin
                m_done = 0; m_avail = 0; m_evt = 1;
            end else if (m_play) begin
                if (out_ready) begin
                    if (m_pos == int'(img[1])) begin m_play = 0; m_done = 1; end
                    else m_pos++;
                end
            end else if (o_avail) begin
                m_play = 1; m_pos = 0;
            end
            if (host_wr_en && !o_avail) begin
                if (int'(host_addr) < IMG) img[host_addr] = host_wr_data;
                else if (int'(host_addr) == CTRL && host_wr_data[0]) m_avail = 1;
            end
            if (out_valid && out_ready) acc_cnt++;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(out_valid == m_play, "R8 valid", out_valid, m_play);
            chk(insert_empty_irq == m_evt, "R9 irq", insert_empty_irq, m_evt);
            if (m_play) begin
                logic lst;
                lst = (m_pos == int'(img[1]));
                chk(out_data == img[3 + m_pos], "R5 data", out_data, img[3 + m_pos]);
                chk(out_sop == (m_pos == 0 && img[0][0]), "R6 sop", out_sop, (m_pos == 0 && img[0][0]));
                chk(out_chan == img[2], "R6 chan", out_chan, img[2]);
                chk(out_last == lst, "R7 last", out_last, lst);
                chk(out_eop == (lst && img[0][1]), "R7 eop", out_eop, (lst && img[0][1]));
                chk(out_err == (lst ? img[0][4:2] : 3'b000), "R7 err", out_err, (lst ? img[0][4:2] : 3'b000));
            end
            if (m_rd_pend) chk(host_rd_data == m_rd_exp, rd_tag, host_rd_data, m_rd_exp);
        end
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready <= 1'b1;
            1: out_ready <= lfsr[0] | lfsr[3];
            default: out_ready <= 1'b0;
        endcase
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic host_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        host_addr = 9'(a); host_wr_data = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_rd(input int a, input string tag);
        @(negedge clk);
        rd_tag = tag; host_addr = 9'(a); host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_burst(input logic [7:0] fl, input logic [7:0] ln, input logic [7:0] ch, input logic [7:0] seed);
        host_wr(0, fl);
        host_wr(1, ln);
        host_wr(2, ch);
        for (int i = 0; i <= int'(ln); i++) host_wr(3 + i, 8'(int'(seed) + i * 7));
    endtask

    task automatic run_burst(input int exp_bytes, input string tag);
        int w;
        acc_cnt = 0;
        host_wr(CTRL, 8'h01);
        w = 0;
        while (!insert_empty_irq && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(insert_empty_irq == 1'b1, "R9 release seen", insert_empty_irq, 1);
        chk(acc_cnt == exp_bytes, tag, acc_cnt, exp_bytes);
        rdy_mode = 0;
    endtask

    initial begin
        for (int i = 0; i < IMG; i++) img[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(insert_empty_irq == 1'b0, "R1 irq", insert_empty_irq, 0);
        host_rd(CTRL, "R1 ctrl");

        // burst A: flags 0xFF (upper bits must read 0), 4 bytes, stalled while host meddles
        load_burst(8'hFF, 8'd3, 8'h2A, 8'h10);
        host_rd(0, "R2 flags");
        host_rd(1, "R2 len");
        host_rd(2, "R2 chan");
        host_rd(4, "R2 payload");
        host_rd(300, "R2 unmapped");
        rdy_mode = 2;
        host_wr(CTRL, 8'h01);
        host_rd(CTRL, "R4 ctrl owned");
        host_wr(3, 8'hEE);
        host_wr(1, 8'h00);
        host_wr(CTRL, 8'h00);
        host_rd(CTRL, "R3 ctrl still owned");
        repeat (20) @(negedge clk);
        chk(out_valid == 1'b1, "R8 stalled valid", out_valid, 1);
        begin
            int w;
            acc_cnt = 0;
            rdy_mode = 0;
            w = 0;
            while (!insert_empty_irq && w < 500) begin @(negedge clk); w++; end
            chk(acc_cnt == 4, "R5 count A", acc_cnt, 4);
        end
        @(negedge clk);
        chk(insert_empty_irq == 1'b0, "R9 pulse width", insert_empty_irq, 0);
        host_rd(3, "R3 payload kept");
        host_rd(1, "R3 len kept");
        host_rd(CTRL, "R9 ctrl freed");

        // burst B: single byte, no flags, random back-pressure
        load_burst(8'h00, 8'd0, 8'h05, 8'h77);
        rdy_mode = 1;
        run_burst(1, "R10 single byte");

        // burst C: single byte carrying every flag
        load_burst(8'h1F, 8'd0, 8'h81, 8'h33);
        run_burst(1, "R10 single byte all flags");

        // burst D: full 256 bytes under random back-pressure
        load_burst(8'h03, 8'd255, 8'hC4, 8'h01);
        rdy_mode = 1;
        run_burst(256, "R10 full burst");
        host_rd(258, "R2 last payload");

        // burst E: error-only flags, medium length, back-to-back with D
        load_burst(8'h14, 8'd9, 8'h3C, 8'hA0);
        run_burst(10, "R5 count E");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule